// File: doc/BRIEF.md
# Memory-Block Synchronous Serial Streamer

This block is a transmit-only synchronous serial port. Once per processing pass, a single-cycle start strobe asks it to read a contiguous run of 32-bit words from a data memory. The words run from a programmable first address up to a programmable last address. The block shifts them out most-significant bit first on a serial data line, next to a serial clock that it divides down from the system clock.

A frame pulse marks group boundaries in the stream. It can mark only the start of the block, or every 8, 16 or 32 bits. A ready strobe can be enabled to cover the whole block transfer. Both strobes have a programmable polarity. The serial clock can run all the time, or it can be gated so that it only toggles while bits are being shifted.

The memory is reached through a simple synchronous read port: the block drives a read enable and an address, and the word is returned on the next clock edge. The block prefetches one word ahead, so the bit stream has no gaps between words.

Top module: `bss_stream_tx`

## Requirements
- R1: Each accepted pass sends every word from `beg_addr` through `end_addr` inclusive, in ascending address order. Each word goes out bit 31 first. `sdata` changes only when `sclk` falls and is stable at the rising edge. A pass therefore produces exactly 32 x (end - beg + 1) data bits, with no gap between words.
- R2: `fast_sel` selects the serial clock rate. With `fast_sel`=0 the `sclk` period is 4 system clocks. With `fast_sel`=1 it is 2 system clocks.
- R3: With `gate_clk`=1, `sclk` stays low except while data bits are being shifted, so it has exactly one rising edge per data bit. With `gate_clk`=0, `sclk` toggles continuously while `en`=1, including between passes.
- R4: `frame_fmt` sets where the frame pulse occurs. Value 0 gives a pulse at bit 0 of the block only. Value 1 gives one every 8 bits, value 2 every 16 bits and value 3 every 32 bits, with bits counted from 0 at the start of the block.
- R5: Each frame pulse lasts exactly one `sclk` period and is aligned with the bit it marks. With `fpol`=0 the pulse is high-active and the idle level is 0. With `fpol`=1 the pulse is low-active and the idle level is 1.
- R6: `rdy` is active from an accepted start until the last bit of the pass has been sent, and inactive between passes. With `rpol`=0 active means 1; with `rpol`=1 active means 0. When `rdy_en`=0 or `en`=0, `rdy` is held at 0.
- R7: While `en`=0, start strobes are ignored and no transfer runs: `rd_en`, `sclk`, `sdata` and `rdy` stay 0, and `fpulse` stays at its inactive level.
- R8: A start strobe that arrives while a pass is in progress is ignored. The current pass completes unchanged, and no second pass follows it.
- R9: A start with `end_addr` <= `beg_addr` sends nothing, issues no read and leaves `rdy` inactive, and it sets `cfg_err` to 1. The next start with a valid range clears `cfg_err` to 0.
- R10: While `rst` is high, `sclk`, `sdata`, `rd_en` and `cfg_err` are 0, `fpulse` is at its inactive level, and `rdy` is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low aborts and idles the port |
| rdy_en | input | 1 | Enables the ready strobe output |
| fast_sel | input | 1 | Serial clock rate: 0 = clk/4, 1 = clk/2 |
| gate_clk | input | 1 | 1 = serial clock only while shifting |
| frame_fmt | input | 2 | Frame pulse spacing: 0 block, 1 / 8 bits, 2 / 16 bits, 3 / 32 bits |
| fpol | input | 1 | Frame pulse polarity: 0 high-active, 1 low-active |
| rpol | input | 1 | Ready strobe polarity: 0 high-active, 1 low-active |
| beg_addr | input | AW | First word address of the block |
| end_addr | input | AW | Last word address of the block |
| start | input | 1 | Single-cycle pass start request |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | AW | Memory read address |
| rd_data | input | 32 | Memory read data, valid the cycle after rd_en |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data, MSB first |
| fpulse | output | 1 | Frame pulse |
| rdy | output | 1 | Ready strobe, active for a whole block |
| cfg_err | output | 1 | Last start had end_addr <= beg_addr |

## Verification
A wrong bit counter or a wrong word pointer shows up on `sdata` within one serial bit, or at the next word boundary. It appears as a data bit that does not match the word in memory, or as a frame pulse at an index the selected spacing does not allow. A wrong fetch or handshake state shows up at the end of the pass, as a bit count that is wrong by a multiple of 32 or as a `rdy` that stays stuck active. Faults in the divider or the gating show up within one serial period, as an interval between rising edges other than 2 or 4 clocks, or as edges on a gated clock outside a transfer.

// File: rtl/bss_pkg.sv
package bss_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        FR_BLOCK = 2'd0,
        FR_8     = 2'd1,
        FR_16    = 2'd2,
        FR_32    = 2'd3
    } frame_fmt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bss_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              vld;
    } word_buf_t;

    // Frame marker for a bit index inside a word, index 0 excluded
    function automatic logic frame_hit(frame_fmt_e fmt, int unsigned idx);
        case (fmt)
            FR_8:    return (idx % 8) == 0;
            FR_16:   return (idx % 16) == 0;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bss_clkdiv.sv
module bss_clkdiv #(
    parameter int DIV_SLOW = 4,
    parameter int DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic sclk_q,
    output logic fall_ev
);
    localparam int HS = DIV_SLOW / 2;
    localparam int HF = DIV_FAST / 2;
    localparam int CW = (HS > 1) ? $clog2(HS) : 1;

    logic [CW-1:0] cnt;
    logic          hdone;

    assign hdone   = fast ? (cnt == CW'(HF - 1)) : (cnt == CW'(HS - 1));
    assign fall_ev = run & hdone & sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (hdone) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    // R2: at the fast rate the divided clock flips every system cycle
    a_r2_fast_toggle: assert property (@(posedge clk) disable iff (rst)
        (run && fast) |=> (sclk_q != $past(sclk_q)));

endmodule

// File: rtl/bss_shifter.sv
module bss_shifter
    import bss_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         fall_ev,
    input  logic         arm,
    input  frame_fmt_e   fmt,
    input  logic         buf_vld,
    input  logic [W-1:0] buf_word,
    output logic         take,
    output logic         done,
    output logic         shifting,
    output logic         bit_out,
    output logic         frame
);
    localparam int BW = $clog2(W);

    logic [W-1:0]  sh;
    logic [BW-1:0] bcnt;
    logic          last_bit;

    assign last_bit = (bcnt == BW'(W - 1));
    assign take     = fall_ev & arm & buf_vld & (~shifting | last_bit);
    assign done     = fall_ev & shifting & last_bit & ~buf_vld;
    assign bit_out  = shifting & sh[W-1];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh       <= '0;
            bcnt     <= '0;
            shifting <= 1'b0;
            frame    <= 1'b0;
        end else if (fall_ev) begin
            if (take) begin
                sh       <= buf_word;
                bcnt     <= '0;
                shifting <= 1'b1;
                frame    <= ~shifting | (fmt != FR_BLOCK);
            end else if (shifting) begin
                if (last_bit) begin
                    sh       <= '0;
                    shifting <= 1'b0;
                    frame    <= 1'b0;
                end else begin
                    sh    <= sh << 1;
                    bcnt  <= bcnt + 1'b1;
                    frame <= frame_hit(fmt, int'(bcnt) + 1);
                end
            end
        end
    end

    // R1: the shift register holds still between serial clock falls
    a_r1_hold_between: assert property (@(posedge clk) disable iff (rst)
        (shifting && !fall_ev && !clr) |=> $stable(sh));

    // R5: an active frame marker lasts until the next serial fall
    a_r5_frame_width: assert property (@(posedge clk) disable iff (rst)
        (frame && !fall_ev && !clr) |=> frame);

    // R4: block-only framing never marks a bit after the first
    a_r4_block_once: assert property (@(posedge clk) disable iff (rst)
        (shifting && fmt == FR_BLOCK && fall_ev && !take && !clr) |=> !frame);

endmodule

// File: rtl/bss_stream_tx.sv
module bss_stream_tx
    import bss_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DIV_SLOW = 4,
    parameter int DIV_FAST = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              rdy_en,
    input  logic              fast_sel,
    input  logic              gate_clk,
    input  logic [1:0]        frame_fmt,
    input  logic              fpol,
    input  logic              rpol,
    input  logic [AW-1:0]     beg_addr,
    input  logic [AW-1:0]     end_addr,
    input  logic              start,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              sclk,
    output logic              sdata,
    output logic              fpulse,
    output logic              rdy,
    output logic              cfg_err
);
    bss_state_e    st;
    logic [AW-1:0] ptr;
    logic          more;
    logic          pend;
    word_buf_t     wbuf;
    logic          cfg_err_q;

    logic sclk_q, fall_ev;
    logic take, done, shifting, bit_out, frame;
    logic range_ok;

    assign range_ok = end_addr > beg_addr;

    bss_clkdiv #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_FAST (DIV_FAST)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (en),
        .fast    (fast_sel),
        .sclk_q  (sclk_q),
        .fall_ev (fall_ev)
    );

    bss_shifter #(
        .W (WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (~en),
        .fall_ev  (fall_ev),
        .arm      (st == ST_RUN),
        .fmt      (frame_fmt_e'(frame_fmt)),
        .buf_vld  (wbuf.vld),
        .buf_word (wbuf.data),
        .take     (take),
        .done     (done),
        .shifting (shifting),
        .bit_out  (bit_out),
        .frame    (frame)
    );

    assign rd_en   = (st == ST_RUN) & more & ~wbuf.vld & ~pend;
    assign rd_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st   <= ST_IDLE;
            ptr  <= '0;
            more <= 1'b0;
            pend <= 1'b0;
            wbuf <= '0;
            if (rst) cfg_err_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        cfg_err_q <= ~range_ok;
                        if (range_ok) begin
                            st   <= ST_RUN;
                            ptr  <= beg_addr;
                            more <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (rd_en) begin
                        pend <= 1'b1;
                        ptr  <= ptr + 1'b1;
                        more <= (ptr != end_addr);
                    end
                    if (pend) begin
                        wbuf.data <= rd_data;
                        wbuf.vld  <= 1'b1;
                        pend      <= 1'b0;
                    end
                    if (take) wbuf.vld <= 1'b0;
                    if (done) begin
                        st   <= ST_IDLE;
                        more <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign sclk    = en & sclk_q & (~gate_clk | shifting);
    assign sdata   = bit_out;
    assign fpulse  = frame ^ fpol;
    assign rdy     = en & rdy_en & ((st == ST_RUN) ^ rpol);
    assign cfg_err = cfg_err_q;

    // R7: disabling the port stops reads and returns to idle
    a_r7_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!rd_en && st == ST_IDLE && !shifting));

    // R8: a start during a pass does not disturb it
    a_r8_busy_start: assert property (@(posedge clk) disable iff (rst)
        (en && st == ST_RUN && start && !done) |=> (st == ST_RUN));

    // R1: reads stay inside the programmed range
    a_r1_read_range: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr >= beg_addr && rd_addr <= end_addr));

    // R6: the ready strobe is active while bits are being shifted
    a_r6_rdy_cover: assert property (@(posedge clk) disable iff (rst)
        (en && rdy_en && !rpol && shifting) |-> rdy);

endmodule

// File: tb/bss_stream_tx_test.sv
module bss_stream_tx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1, rdy_en = 1'b1, fast_sel = 1'b1, gate_clk = 1'b1;
    logic [1:0]  frame_fmt = 2'd0;
    logic        fpol = 1'b0, rpol = 1'b0;
    logic [7:0]  beg_addr = 8'd0, end_addr = 8'd0;
    logic        start = 1'b0;
    logic        rd_en;
    logic [7:0]  rd_addr;
    logic [31:0] rd_data = 32'd0;
    logic        sclk, sdata, fpulse, rdy, cfg_err;

    int nvec = 0;
    int nbad = 0;
    logic [31:0] mem [0:63];

    always #5 clk = ~clk;

    bss_stream_tx uut (
        .clk(clk), .rst(rst), .en(en), .rdy_en(rdy_en), .fast_sel(fast_sel),
        .gate_clk(gate_clk), .frame_fmt(frame_fmt), .fpol(fpol), .rpol(rpol),
        .beg_addr(beg_addr), .end_addr(end_addr), .start(start),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .sclk(sclk), .sdata(sdata), .fpulse(fpulse), .rdy(rdy), .cfg_err(cfg_err)
    );

    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[5:0]];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sclk == 1'b0,   "R10", "sclk in reset", int'(sclk), 0);
        chk(sdata == 1'b0,  "R10", "sdata in reset", int'(sdata), 0);
        chk(rd_en == 1'b0,  "R10", "rd_en in reset", int'(rd_en), 0);
        chk(fpulse == 1'b0, "R10", "fpulse in reset", int'(fpulse), 0);
        chk(rdy == 1'b0,    "R10", "rdy in reset", int'(rdy), 0);
        chk(cfg_err == 1'b0,"R10", "cfg_err in reset", int'(cfg_err), 0);
    endtask

    // one full pass, collecting the stream at sclk rising edges
    task automatic xfer(input int b, input int e, input int f, input bit fast,
                        input bit gate, input bit fp_pol, input bit rp,
                        input bit re, input bit poke, input string tag);
        int  nexp = (e - b + 1) * 32;
        int  per = fast ? 2 : 4;
        int  spacing = (f == 0) ? 0 : (4 << f);
        int  npulse = (f == 0) ? 1 : nexp / spacing;
        int  n = 0, cyc = 0, last_rise = 0, quiet = 0;
        int  bad_data = 0, bad_fp = 0, bad_per = 0, fp_cyc = 0, extra = 0;
        int  post_rise = 0, post_rd = 0;
        bit  prev = 1'b0, coll = 1'b0, fa, rdy_mid = 1'b0;
        @(negedge clk);
        beg_addr = 8'(b); end_addr = 8'(e); frame_fmt = 2'(f);
        fast_sel = fast; gate_clk = gate; fpol = fp_pol; rpol = rp; rdy_en = re;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (quiet < 40 && cyc < 6000) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            fa = (fpulse != fp_pol);
            if (fa) fp_cyc++;
            if (sclk && !prev) begin
                if ((coll || fa) && n < nexp) begin
                    coll = 1'b1;
                    if (sdata != mem[b + n / 32][31 - (n % 32)]) bad_data++;
                    if (fa != ((f == 0) ? (n == 0) : ((n % spacing) == 0))) bad_fp++;
                    if (n > 0 && (cyc - last_rise) != per) bad_per++;
                    last_rise = cyc;
                    if (n == nexp / 2) rdy_mid = rdy;
                    n++;
                    if (poke && n == 40) start = 1'b1;
                end else if (gate) begin
                    extra++;
                end
            end
            prev = sclk;
            if (n >= nexp) quiet++;
        end
        chk(n == nexp, "R1", {tag, " bit count"}, n, nexp);
        chk(bad_data == 0, "R1", {tag, " data bits"}, bad_data, 0);
        chk(bad_fp == 0, "R4", {tag, " frame positions"}, bad_fp, 0);
        chk(bad_per == 0, "R2", {tag, " sclk period"}, bad_per, 0);
        chk(fp_cyc == npulse * per, "R5", {tag, " frame width"}, fp_cyc, npulse * per);
        if (gate) chk(extra == 0, "R3", {tag, " gated edges"}, extra, 0);
        chk(rdy_mid == (re & ~rp), "R6", {tag, " rdy during"}, int'(rdy_mid), int'(re & ~rp));
        chk(rdy == (re & rp), "R6", {tag, " rdy after"}, int'(rdy), int'(re & rp));
        prev = sclk;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sclk && !prev) post_rise++;
            if (rd_en) post_rd++;
            prev = sclk;
        end
        if (gate) chk(post_rise == 0, "R3", {tag, " gated idle"}, post_rise, 0);
        else      chk(post_rise >= 8, "R3", {tag, " free-running idle"}, post_rise, 8);
        if (poke) chk(post_rd == 0, "R8", {tag, " no second pass"}, post_rd, 0);
    endtask

    task automatic t_disabled();
        int hi = 0, rd = 0, dat = 0, ry = 0, fp = 0;
        @(negedge clk);
        en = 1'b0; gate_clk = 1'b0; rdy_en = 1'b1; rpol = 1'b0; fpol = 1'b0;
        beg_addr = 8'd2; end_addr = 8'd4;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sclk) hi++;
            if (rd_en) rd++;
            if (sdata) dat++;
            if (rdy) ry++;
            if (fpulse) fp++;
        end
        chk(hi == 0, "R7", "sclk while disabled", hi, 0);
        chk(rd == 0, "R7", "reads while disabled", rd, 0);
        chk(dat + ry + fp == 0, "R7", "sdata/rdy/fpulse while disabled", dat + ry + fp, 0);
        en = 1'b1;
    endtask

    task automatic t_cfg_err(input int b, input int e, input string tag);
        int rd = 0, ry = 0;
        @(negedge clk);
        beg_addr = 8'(b); end_addr = 8'(e); rdy_en = 1'b1; rpol = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rd_en) rd++;
            if (rdy) ry++;
        end
        chk(cfg_err == 1'b1, "R9", {tag, " cfg_err set"}, int'(cfg_err), 1);
        chk(rd == 0, "R9", {tag, " no reads"}, rd, 0);
        chk(ry == 0, "R9", {tag, " rdy idle"}, ry, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++)
            mem[i] = {8'(i) ^ 8'h5A, ~8'(i), 8'hC3 + 8'(i), 8'(i * 7)};
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        //    beg end fmt fast gate fpol rpol rdy_en poke
        xfer(3,  5,  0,  1,   1,   0,   0,   1,     0, "R1 fast gated block");
        xfer(10, 11, 1,  0,   1,   0,   0,   1,     0, "R4 slow fmt8");
        xfer(20, 22, 2,  1,   0,   1,   1,   1,     0, "R5 fmt16 inverted free");
        xfer(30, 33, 3,  0,   1,   0,   0,   0,     0, "R6 fmt32 rdy off");
        xfer(40, 42, 1,  1,   1,   0,   0,   1,     1, "R8 busy start");
        t_disabled();
        t_cfg_err(12, 12, "R9 equal");
        t_cfg_err(15, 9, "R9 reversed");
        xfer(50, 51, 0,  0,   0,   0,   1,   1,     0, "R9 recover");
        chk(cfg_err == 1'b0, "R9", "cfg_err cleared", int'(cfg_err), 0);
        finish_run();
    end

endmodule